// File: doc/BRIEF.md
# Two-Crossing Late Segment Window

This block sits at the front of a pipelined track trigger. On every bunch-crossing clock it receives a fixed set of segment slots. The slots are split into station groups, and each slot carries a valid bit and a data record. Segments can arrive one crossing late but never early. The block therefore holds every segment of the previous crossing for exactly one clock and offers it again in the following crossing.

On each crossing the block produces a complete output set for the current crossing. A valid current segment always keeps its own slot. A slot that is empty in the current crossing may take a held segment from the same group. That segment is marked with a late flag. Downstream logic uses the flag to drop a track built only from late segments, so the same hit does not trigger twice. Because the time buckets overlap, a segment is seen as current in one crossing and may be offered as late in the next.

The output is registered, with one clock of latency from the input.

Top module: `wnd_late_window`

## Requirements
- R1: A synchronous reset clears all outputs and all held segments. In the first crossing after reset, no slot is late-filled.
- R2: A valid input segment in slot n appears in output slot n on the next clock, with valid=1, late=0 and its data unchanged.
- R3: An output slot whose current input is empty may be filled with a segment that arrived in the same group one crossing earlier. Such a slot has valid=1 and late=1.
- R4: Within a group, the empty current slots are taken in ascending slot order. The k-th empty slot receives the k-th valid held segment, with held segments also counted in ascending slot order.
- R5: Held segments left over after all empty slots are used are dropped. Empty slots left over after all held segments are used have valid=0, late=0 and data=0.
- R6: A held segment is offered only in the crossing right after its arrival. Two crossings later it no longer appears.
- R7: Groups are independent. A held segment fills only slots of its own group.
- R8: The late flag is never 1 on a slot whose valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | GROUPS*SLOTS | Valid bit per input slot; slot index = group*SLOTS + position |
| in_data | input | GROUPS*SLOTS*SEG_W | Segment record per input slot |
| out_vld | output | GROUPS*SLOTS | Valid bit per output slot |
| out_late | output | GROUPS*SLOTS | 1 when the slot carries a segment from the previous crossing |
| out_data | output | GROUPS*SLOTS*SEG_W | Segment record per output slot; zero when invalid |

## Verification
The assertions assume that in_vld and in_data are stable and known at each rising edge. They also assume that a slot's data is meaningful only while its valid bit is set. The checker therefore compares data only on slots whose current input is valid, and it derives the late-fill count from the valid patterns alone. The stimulus changes inputs only on the falling edge and gives every slot a distinct record for each crossing, so a wrongly routed or stale segment shows up as a mismatch. It sweeps every pair of held and current valid patterns per group, with the groups given swapped patterns. It also covers a pattern followed by idle crossings and a reset asserted while segments are held.

// File: rtl/wnd_pkg.sv
package wnd_pkg;
    localparam int SEG_W = 8;

    typedef struct packed {
        logic             vld;
        logic             late;
        logic [SEG_W-1:0] data;
    } slot_t;
endpackage

// File: rtl/wnd_hold_bank.sv
module wnd_hold_bank #(
    parameter int NSLOT = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NSLOT-1:0]                cur_vld,
    input  logic [NSLOT*wnd_pkg::SEG_W-1:0] cur_data,
    output logic [NSLOT-1:0]                held_vld,
    output logic [NSLOT*wnd_pkg::SEG_W-1:0] held_data
);
    typedef struct packed {
        logic [NSLOT-1:0]                vld;
        logic [NSLOT*wnd_pkg::SEG_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d.vld  = cur_vld;
        hold_d.data = cur_data;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign held_vld  = hold_q.vld;
    assign held_data = hold_q.data;
endmodule

// File: rtl/wnd_slot_merge.sv
module wnd_slot_merge #(
    parameter int SLOTS = 3
) (
    input  logic [SLOTS-1:0]                cur_vld,
    input  logic [SLOTS*wnd_pkg::SEG_W-1:0] cur_data,
    input  logic [SLOTS-1:0]                held_vld,
    input  logic [SLOTS*wnd_pkg::SEG_W-1:0] held_data,
    output wnd_pkg::slot_t [SLOTS-1:0]      merged
);
    localparam int SW = wnd_pkg::SEG_W;

    int   empty_rank;
    int   held_rank;
    logic taken;

    always_comb begin
        merged     = '0;
        empty_rank = 0;
        held_rank  = 0;
        taken      = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (cur_vld[s]) begin
                merged[s].vld  = 1'b1;
                merged[s].late = 1'b0;
                merged[s].data = cur_data[s*SW +: SW];
            end else begin
                held_rank = 0;
                taken     = 1'b0;
                for (int h = 0; h < SLOTS; h++) begin
                    if (held_vld[h]) begin
                        if (!taken && held_rank == empty_rank) begin
                            merged[s].vld  = 1'b1;
                            merged[s].late = 1'b1;
                            merged[s].data = held_data[h*SW +: SW];
                            taken          = 1'b1;
                        end
                        held_rank = held_rank + 1;
                    end
                end
                empty_rank = empty_rank + 1;
            end
        end
    end
endmodule

// File: rtl/wnd_late_window.sv
module wnd_late_window #(
    parameter int GROUPS = 4,
    parameter int SLOTS  = 3
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [GROUPS*SLOTS-1:0]                in_vld,
    input  logic [GROUPS*SLOTS*wnd_pkg::SEG_W-1:0] in_data,
    output logic [GROUPS*SLOTS-1:0]                out_vld,
    output logic [GROUPS*SLOTS-1:0]                out_late,
    output logic [GROUPS*SLOTS*wnd_pkg::SEG_W-1:0] out_data
);
    localparam int SW    = wnd_pkg::SEG_W;
    localparam int NSLOT = GROUPS * SLOTS;
    localparam int GW    = SLOTS * SW;

    logic [NSLOT-1:0]         held_vld;
    logic [NSLOT*SW-1:0]      held_data;
    wnd_pkg::slot_t [NSLOT-1:0] merged;

    wnd_hold_bank #(.NSLOT(NSLOT)) i_hold (
        .clk      (clk),
        .rst      (rst),
        .cur_vld  (in_vld),
        .cur_data (in_data),
        .held_vld (held_vld),
        .held_data(held_data)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        wnd_slot_merge #(.SLOTS(SLOTS)) i_merge (
            .cur_vld  (in_vld[g*SLOTS +: SLOTS]),
            .cur_data (in_data[g*GW +: GW]),
            .held_vld (held_vld[g*SLOTS +: SLOTS]),
            .held_data(held_data[g*GW +: GW]),
            .merged   (merged[g*SLOTS +: SLOTS])
        );
    end

    typedef struct packed {
        logic [NSLOT-1:0]    vld;
        logic [NSLOT-1:0]    late;
        logic [NSLOT*SW-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        for (int i = 0; i < NSLOT; i++) begin
            out_d.vld[i]            = merged[i].vld;
            out_d.late[i]           = merged[i].late;
            out_d.data[i*SW +: SW]  = merged[i].data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_vld  = out_q.vld;
    assign out_late = out_q.late;
    assign out_data = out_q.data;
endmodule

// File: rtl/wnd_late_window_chk.sv
module wnd_late_window_chk #(
    parameter int GROUPS = 4,
    parameter int SLOTS  = 3
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic [GROUPS*SLOTS-1:0]                in_vld,
    input logic [GROUPS*SLOTS*wnd_pkg::SEG_W-1:0] in_data,
    input logic [GROUPS*SLOTS-1:0]                out_vld,
    input logic [GROUPS*SLOTS-1:0]                out_late,
    input logic [GROUPS*SLOTS*wnd_pkg::SEG_W-1:0] out_data
);
    localparam int SW    = wnd_pkg::SEG_W;
    localparam int NSLOT = GROUPS * SLOTS;

    logic [NSLOT-1:0]    cur_q;
    logic [NSLOT*SW-1:0] curd_q;
    logic [NSLOT-1:0]    old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            curd_q <= '0;
            old_q  <= '0;
        end else begin
            cur_q  <= in_vld;
            curd_q <= in_data;
            old_q  <= cur_q;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (out_vld == '0 && out_late == '0)); // R1

    AST_LATE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (out_late & ~out_vld) == '0); // R8

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        AST_CURRENT_PASS: assert property (@(posedge clk) disable iff (rst)
            cur_q[i] |-> (out_vld[i] && !out_late[i] &&
                          out_data[i*SW +: SW] == curd_q[i*SW +: SW])); // R2
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        int unsigned n_empty, n_old, n_late, n_want;
        logic        prefix_ok;
        logic        seen_gap;

        always_comb begin
            n_empty   = SLOTS - $countones(cur_q[g*SLOTS +: SLOTS]);
            n_old     = $countones(old_q[g*SLOTS +: SLOTS]);
            n_late    = $countones(out_late[g*SLOTS +: SLOTS]);
            n_want    = (n_empty < n_old) ? n_empty : n_old;
            prefix_ok = 1'b1;
            seen_gap  = 1'b0;
            for (int s = 0; s < SLOTS; s++) begin
                if (!cur_q[g*SLOTS + s]) begin
                    if (out_vld[g*SLOTS + s] && seen_gap) prefix_ok = 1'b0;
                    if (!out_vld[g*SLOTS + s]) seen_gap = 1'b1;
                end
            end
        end

        AST_LATE_COUNT: assert property (@(posedge clk) disable iff (rst)
            n_late == n_want); // R6

        AST_FILL_ORDER: assert property (@(posedge clk) disable iff (rst)
            prefix_ok); // R4
    end
endmodule

bind wnd_late_window wnd_late_window_chk #(.GROUPS(GROUPS), .SLOTS(SLOTS)) i_chk (.*);

// File: tb/test_wnd_late_window.sv
module test_wnd_late_window;
    localparam int G  = 2;
    localparam int S  = 3;
    localparam int N  = G * S;
    localparam int SW = wnd_pkg::SEG_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    in_vld  = '0;
    logic [N*SW-1:0] in_data = '0;
    logic [N-1:0]    out_vld;
    logic [N-1:0]    out_late;
    logic [N*SW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int tag    = 0;

    logic [N-1:0]    prev_vld  = '0;
    logic [N*SW-1:0] prev_data = '0;
    logic [N-1:0]    exp_vld, exp_late;
    logic [N*SW-1:0] exp_data;

    wnd_late_window #(.GROUPS(G), .SLOTS(S)) i_wnd_late_window (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
        .out_vld(out_vld), .out_late(out_late), .out_data(out_data)
    );

    always #2 clk = ~clk;

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input logic [N-1:0] v, input logic [N*SW-1:0] d, input logic r);
        exp_vld = '0; exp_late = '0; exp_data = '0;
        if (!r) begin
            for (int g = 0; g < G; g++) begin
                int er;
                er = 0;
                for (int s = 0; s < S; s++) begin
                    int idx;
                    idx = g*S + s;
                    if (v[idx]) begin
                        exp_vld[idx] = 1'b1;
                        exp_data[idx*SW +: SW] = d[idx*SW +: SW];
                    end else begin
                        int hr;
                        hr = 0;
                        for (int h = 0; h < S; h++) begin
                            if (prev_vld[g*S + h]) begin
                                if (hr == er) begin
                                    exp_vld[idx]  = 1'b1;
                                    exp_late[idx] = 1'b1;
                                    exp_data[idx*SW +: SW] = prev_data[(g*S + h)*SW +: SW];
                                end
                                hr++;
                            end
                        end
                        er++;
                    end
                end
            end
        end
    endtask

    task automatic step(input logic [N-1:0] v, input logic r, input string req);
        logic [N*SW-1:0] d;
        @(negedge clk);
        tag = (tag + 1) % 16;
        for (int i = 0; i < N; i++) d[i*SW +: SW] = SW'((tag << 4) | i);
        rst = r; in_vld = v; in_data = d;
        @(posedge clk);
        model(v, d, r);
        prev_vld  = r ? '0 : v;
        prev_data = r ? '0 : d;
        #1;
        for (int i = 0; i < N; i++) begin
            string rq;
            if (req != "") rq = req;
            else if (i >= S) rq = "R7";
            else if (exp_late[i]) rq = "R4";
            else if (exp_vld[i]) rq = "R2";
            else rq = "R5";
            check({rq, " vld"},  int'(out_vld[i]),  int'(exp_vld[i]));
            check({rq, " late"}, int'(out_late[i]), int'(exp_late[i]));
            check({rq, " data"}, int'(out_data[i*SW +: SW]), int'(exp_data[i*SW +: SW]));
            if (out_late[i] && !out_vld[i]) check("R8 late without valid", 1, 0);
        end
    endtask

    initial begin
        // R1: reset state
        step('0, 1'b1, "R1");
        step('0, 1'b1, "R1");
        // R1: first crossing after reset has nothing to fill from
        step(6'b000_000, 1'b0, "R1");
        // R3/R4/R5/R7: all held x current pattern pairs, groups swapped
        for (int c = 0; c < 64; c++) begin
            logic [2:0] h, cu;
            h  = 3'(c);
            cu = 3'(c >> 3);
            step({cu, h}, 1'b0, "");
            step({h, cu}, 1'b0, (h == 3'b000 && cu != 3'b111) ? "" : "");
        end
        // R3: full held set into empty crossing
        step(6'b111_111, 1'b0, "");
        step(6'b000_000, 1'b0, "R3");
        // R6: two crossings later nothing remains
        step(6'b000_000, 1'b0, "R6");
        // R1: reset while segments are held
        step(6'b101_011, 1'b0, "");
        step(6'b111_111, 1'b1, "R1");
        step(6'b000_000, 1'b0, "R1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule